// File: doc/BRIEF.md
# Three-block permutation hash engine

This block hashes one 32-byte message that the caller has already padded. The message is written a byte at a time into an internal buffer, and a start pulse begins the hash. The engine first folds the message into a 16-byte checksum, and then mixes three 16-byte blocks (the two message halves, then the checksum) through a 48-byte working state. The mixing uses 18 rounds per block. Every step goes through one fixed byte permutation. A one-cycle done pulse marks the end of the run.

After the run, the first 16 state bytes are the digest. The other 32 bytes are left in place as residual data. A read port exposes all 48 bytes, so the caller can fetch the residual as well as the digest. Only the low 16 state bytes are cleared when a run begins; the upper 32 keep whatever the previous run left. The caller supplies the pad: the pad value is the number of padded bytes, so one pad byte of value 1 sits in byte 31. The engine performs one permutation lookup per clock.

Top module: `perm_hash48`

## Requirements
- R1: While rst_n is low and after it is released, busy and done are 0 and every state byte read through rd_addr 0..47 is 0x00.
- R2: When busy is 0, ld_en writes ld_data to message byte ld_addr (0..31, where byte 31 is the last). While busy is 1, ld_en has no effect.
- R3: The permutation S(v) is computed in four steps, all arithmetic mod 256: a = 167*v + 41; b = a ^ (a >> 3); c = 29*b + 101; S = c ^ (c >> 4).
- R4: The checksum C[0..15] starts at zero with L = 0. For each message byte c at index i = 0..31, with j = i mod 16, the engine sets C[j] ^= S[c ^ L] and then L = C[j].
- R5: When a run is accepted, X[0..15] is cleared. For each block B (message bytes 0..15, then message bytes 16..31, then C), and for j = 0..15, the engine sets X[16+j] = B[j] and X[32+j] = B[j] ^ X[j].
- R6: After each block load, 18 rounds run from t = 0. Round r performs X[k] ^= S[t] and then t = X[k] for k = 0..47 in order, and then sets t = (t + r) mod 256.
- R7: After a run, rd_addr 0..15 returns the digest X[0..15] and rd_addr 16..47 returns the residual X[16..47]. Addresses 48 and above read 0x00.
- R8: Suppose start is high at a rising edge while busy is 0. Then busy is 1 after that edge. Done is 1 for exactly one cycle after the 2627th following edge, and busy returns to 0 at that same edge.
- R9: A start pulse while busy is 1 is ignored. The run in progress keeps its timing and its result, and no new run follows it.
- R10: While idle with start low, the state does not change. The digest depends only on the message, so a repeated message gives the same digest whatever residual is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Message byte write enable |
| ld_addr | input | 5 | Message byte index |
| ld_data | input | 8 | Message byte value |
| start | input | 1 | Begin a hash run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rd_addr | input | 6 | State byte index (0..15 digest, 16..47 residual) |
| rd_data | output | 8 | State byte value, combinational from rd_addr |

## Verification
Busy is due one edge after the start edge. Done and the fall of busy are due at the 2627th edge after that. This count is 32 checksum steps plus three blocks of one load cycle and 864 mixing cycles each. The bench counts edges from the start edge and samples 1 ns after each one, so a run that ends one cycle early or late shows up as a latency mismatch. Rd_data follows rd_addr within the same cycle, so state bytes are read at the falling edge once a run has ended. They are compared with a model computed from R3 to R6. An ignored start and an ignored write are judged by the latency, the digest and the cycle after done of the run in which they were injected.

// File: rtl/perm_hash48.sv
module perm_hash48 #(
  parameter int BLK    = 16,
  parameter int ROUNDS = 18
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ld_en,
  input  logic [$clog2(2*BLK)-1:0]     ld_addr,
  input  logic [7:0]                   ld_data,
  input  logic                         start,
  output logic                         busy,
  output logic                         done,
  input  logic [$clog2(3*BLK)-1:0]     rd_addr,
  output logic [7:0]                   rd_data
);
  localparam int MSG = 2 * BLK;
  localparam int ST  = 3 * BLK;
  localparam int MW  = $clog2(MSG);
  localparam int SW  = $clog2(ST);
  localparam int BW  = $clog2(BLK);
  localparam int RW  = $clog2(ROUNDS);

  typedef enum logic [1:0] {IDLE, CSUM, LOAD, MIX} st_t;

  st_t           st;
  logic [7:0]    msg  [MSG];
  logic [7:0]    csum [BLK];
  logic [7:0]    x    [ST];
  logic [7:0]    lreg, t;
  logic [MW-1:0] ci;
  logic [SW-1:0] k;
  logic [RW-1:0] rnd;
  logic [1:0]    blk;

  function automatic logic [7:0] perm(input logic [7:0] v);
    logic [7:0] a, b, c;
    a = v * 8'd167 + 8'd41;
    b = a ^ (a >> 3);
    c = b * 8'd29 + 8'd101;
    return c ^ (c >> 4);
  endfunction

  logic [7:0] sb_in, sb_out, cs_new, mix_new;
  assign sb_in   = (st == CSUM) ? (msg[ci] ^ lreg) : t;
  assign sb_out  = perm(sb_in);
  assign cs_new  = csum[ci[BW-1:0]] ^ sb_out;
  assign mix_new = x[k] ^ sb_out;

  assign busy    = (st != IDLE);
  assign rd_data = (int'(rd_addr) < ST) ? x[rd_addr] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      done <= 1'b0;
      lreg <= '0;
      t    <= '0;
      ci   <= '0;
      k    <= '0;
      rnd  <= '0;
      blk  <= '0;
      for (int i = 0; i < MSG; i++) msg[i]  <= '0;
      for (int i = 0; i < BLK; i++) csum[i] <= '0;
      for (int i = 0; i < ST; i++)  x[i]    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: begin
          if (ld_en) msg[ld_addr] <= ld_data;
          if (start) begin
            st   <= CSUM;
            ci   <= '0;
            lreg <= '0;
            for (int i = 0; i < BLK; i++) begin
              csum[i] <= '0;
              x[i]    <= '0;
            end
          end
        end
        CSUM: begin
          csum[ci[BW-1:0]] <= cs_new;
          lreg <= cs_new;
          ci   <= ci + 1'b1;
          if (int'(ci) == MSG - 1) begin
            st  <= LOAD;
            blk <= '0;
          end
        end
        LOAD: begin
          for (int j = 0; j < BLK; j++) begin
            logic [7:0] mb;
            mb = (blk == 2'd0) ? msg[j] : (blk == 2'd1) ? msg[BLK + j] : csum[j];
            x[BLK + j]   <= mb;
            x[2*BLK + j] <= mb ^ x[j];
          end
          t   <= '0;
          k   <= '0;
          rnd <= '0;
          st  <= MIX;
        end
        MIX: begin
          x[k] <= mix_new;
          if (int'(k) == ST - 1) begin
            k <= '0;
            t <= mix_new + 8'(rnd);
            if (int'(rnd) == ROUNDS - 1) begin
              if (blk == 2'd2) begin
                st   <= IDLE;
                done <= 1'b1;
              end else begin
                blk <= blk + 1'b1;
                st  <= LOAD;
              end
            end else begin
              rnd <= rnd + 1'b1;
            end
          end else begin
            k <= k + 1'b1;
            t <= mix_new;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module perm_hash48_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [5:0] rd_addr,
  input logic [7:0] rd_data
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R8
  AST_BUSY_FALLS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R8
  AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R8
  AST_RUN_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> (busy || done)); // R9
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (rd_addr != $past(rd_addr) || rd_data == $past(rd_data))); // R10
endmodule

bind perm_hash48 perm_hash48_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sim_perm_hash48.sv
`timescale 1ns/1ps
module sim_perm_hash48;
  localparam int LAT = 32 + 3 * (1 + 18 * 48);
  localparam int NV  = 4;
  localparam logic [255:0] VEC [NV] = '{
    {8'h01, 248'h0},
    {8'h01, {31{8'hFF}}},
    {8'h01, 248'h1e1d1c1b1a191817161514131211100f0e0d0c0b0a09080706050403020100},
    {8'h01, {15{8'h00}}, {16{8'h80}}}
  };

  logic       clk = 0, rst_n = 0, ld_en = 0, start = 0;
  logic [4:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [5:0] rd_addr = '0;
  logic       busy, done;
  logic [7:0] rd_data;

  int n_chk = 0, n_bad = 0;
  logic [7:0] ref_x [48];

  always #5 clk = ~clk;

  perm_hash48 u0 (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .start(start), .busy(busy), .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] sref(input logic [7:0] v);
    logic [7:0] a, b, c;
    a = v * 8'd167 + 8'd41;
    b = a ^ (a >> 3);
    c = b * 8'd29 + 8'd101;
    return c ^ (c >> 4);
  endfunction

  task automatic ref_hash(input logic [255:0] m);
    logic [7:0] c [16];
    logic [7:0] xs [48];
    logic [7:0] l, tt, mb;
    for (int i = 0; i < 16; i++) c[i] = 0;
    for (int i = 0; i < 48; i++) xs[i] = 0;
    l = 0;
    for (int i = 0; i < 32; i++) begin
      c[i % 16] = c[i % 16] ^ sref(m[8*i +: 8] ^ l);
      l = c[i % 16];
    end
    for (int b = 0; b < 3; b++) begin
      for (int j = 0; j < 16; j++) begin
        mb = (b < 2) ? m[8*(16*b + j) +: 8] : c[j];
        xs[16 + j] = mb;
        xs[32 + j] = mb ^ xs[j];
      end
      tt = 0;
      for (int r = 0; r < 18; r++) begin
        for (int kk = 0; kk < 48; kk++) begin
          xs[kk] = xs[kk] ^ sref(tt);
          tt = xs[kk];
        end
        tt = tt + 8'(r);
      end
    end
    for (int i = 0; i < 48; i++) ref_x[i] = xs[i];
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_msg(input logic [255:0] m);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      ld_en = 1; ld_addr = 5'(i); ld_data = m[8*i +: 8];
    end
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic cmp_range(input int lo, input int hi, input string req);
    int bad_i = -1;
    logic [7:0] got = 0;
    for (int a = lo; a <= hi; a++) begin
      @(negedge clk);
      rd_addr = 6'(a);
      #1;
      if (rd_data !== ref_x[a] && bad_i < 0) begin bad_i = a; got = rd_data; end
    end
    if (bad_i < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, got, ref_x[bad_i]);
  endtask

  task automatic run_hash(input bit inject, input string tag);
    int lat = 0;
    @(negedge clk); start = 1;
    @(posedge clk); #1;
    chk(busy === 1'b1, "R8 busy after start", busy, 1);
    @(negedge clk); start = 0;
    while (done !== 1'b1 && lat < 5000) begin
      @(posedge clk); #1;
      lat++;
      if (inject && lat == 100) begin
        start = 1; ld_en = 1; ld_addr = 5'd0; ld_data = 8'hEE;
      end
      if (inject && lat == 101) begin
        start = 0; ld_en = 0;
      end
    end
    chk(lat == LAT, {tag, " R8 done latency"}, lat, LAT);
    chk(busy === 1'b0, {tag, " R8 busy low with done"}, busy, 0);
    @(posedge clk); #1;
    chk(done === 1'b0, {tag, " R8 done one cycle"}, done, 0);
    chk(busy === 1'b0, {tag, " R9 no restart"}, busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(busy === 1'b0 && done === 1'b0, "R1 flags in reset", {busy, done}, 0);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 48; i++) ref_x[i] = 0;
    cmp_range(0, 47, "R1 state zero after reset");
    @(negedge clk); rd_addr = 6'd50; #1;
    chk(rd_data === 8'h00, "R7 out-of-range read", rd_data, 0);

    // R2 R3 R4 R5 R6 R7: table of messages walked by one loop
    for (int v = 0; v < NV; v++) begin
      load_msg(VEC[v]);
      ref_hash(VEC[v]);
      run_hash(1'b0, "vector");
      cmp_range(0, 15, "R6 digest");
      cmp_range(16, 47, "R7 residual");
    end

    // R9 start and R2 write injected mid-run
    load_msg(VEC[2]);
    ref_hash(VEC[2]);
    run_hash(1'b1, "inject");
    cmp_range(0, 15, "R9 digest after ignored start/write");
    cmp_range(16, 47, "R9 residual after ignored start/write");

    // R10 idle stability
    repeat (20) @(posedge clk);
    cmp_range(0, 47, "R10 idle state stable");

    // R10 repeat of first message with other residual present
    load_msg(VEC[0]);
    ref_hash(VEC[0]);
    run_hash(1'b0, "repeat");
    cmp_range(0, 15, "R10 repeated digest");

    // R1 reset in the middle of a run
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (50) @(posedge clk);
    @(negedge clk); rst_n = 0;
    #1;
    chk(busy === 1'b0 && done === 1'b0, "R1 flags on mid-run reset", {busy, done}, 0);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 48; i++) ref_x[i] = 0;
    cmp_range(0, 47, "R1 state zero after mid-run reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule